// File: doc/BRIEF.md
# Soft-Edge Slow PWM Generator

This block drives one output pin with a slow pulse-width modulation of roughly 30 Hz, meant for a large resistive load whose switching edges would otherwise be audible. No edge of the slow waveform is sharp. Each switch-on is replaced by a burst of fast PWM periods whose high time widens step by step. Each switch-off is replaced by a burst whose low time widens in the same way. The load therefore sees a gradual change in average drive instead of a step.

A 7-bit duty command is doubled into an 8-bit threshold. That threshold is compared with an 8-bit wrapping phase counter that advances once per slow tick. A slow tick is a fixed number of fast PWM periods. An eight-state sequencer walks through these phases in order:

- idle start
- steady off
- guard
- rising ramp
- guard
- steady on
- falling ramp
- guard

A hold input freezes the output in either steady level for short measurement windows.

Top module: `soft_edge_pwm`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in its idle-start state with the output low and the phase counter at zero.
- R2: In idle start, the command is sampled on every slow tick. A zero command keeps the block idle with the output low. A nonzero command moves it on to the steady off phase at that tick.
- R3: One fast period is 2^FAST_W clocks, and state changes only at the end of a fast period. Steady phases advance once per slow tick, which is SLOW_DIV fast periods counted from the start of the steady phase.
- R4: In the steady off phase the 8-bit phase counter adds one per slow tick and wraps. The rise is entered at the first tick where the new count is at or below the threshold (command times two). With a steady command D, the low stretch between ramps lasts (3 + (257 - 2D)·SLOW_DIV) fast periods.
- R5: The rise ramp is 16 fast periods. In period k (k = 1 to 16) the output is high for the first k·2^FAST_W/16 clocks and low for the rest.
- R6: In the steady on phase the counter keeps adding one per slow tick, and the fall starts at the first tick where the new count is not below the threshold. A doubled command of 253 or more (command 127) stays on indefinitely. The high stretch is (2 + n·SLOW_DIV) fast periods, where n = 2D - 1 in the first cycle after reset and 2D afterwards.
- R7: The fall ramp is 16 fast periods. In period k the output is low for the first k·2^FAST_W/16 clocks and high for the rest. After the ramp the block returns to idle start.
- R8: A guard period of one full fast period holds the output constant at each of three points: low before the rise, high after the rise, and low after the fall. No pulse on the output is shorter than one compare step (2^FAST_W/16 clocks).
- R9: While hold is asserted, the block neither leaves idle start nor leaves steady on, and the phase counter is frozen there. The output keeps its level until hold is released, after which the sequence resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_cmd | input | DUTY_W | Slow duty command |
| hold | input | 1 | Freeze in idle start or steady on |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions take for granted that reset is held for at least one clock and that the command is static within any slow tick whose decision they check. The full-on property compares the live command in the same cycle as the decision. The stimulus changes the command and hold only at negative clock edges. It changes them only between test cases or at points where the sequencer is known to sit in a steady phase, so every property sees a consistent command. The ramp shapes and dwell lengths are measured as output run lengths, so they do not depend on the fast counter's phase.

// File: rtl/sep_pkg.sv
package sep_pkg;

    typedef enum logic [2:0] {
        ST_OFF_START = 3'd0,
        ST_OFF       = 3'd1,
        ST_OFF2RISE  = 3'd2,
        ST_RISE      = 3'd3,
        ST_RISE2ON   = 3'd4,
        ST_ON        = 3'd5,
        ST_FALL      = 3'd6,
        ST_FALL2OFF  = 3'd7
    } seq_state_e;

    function automatic logic is_steady(input seq_state_e s);
        return (s == ST_OFF_START) || (s == ST_OFF) || (s == ST_ON);
    endfunction

endpackage

// File: rtl/sep_timebase.sv
module sep_timebase #(
    parameter int FAST_W   = 8,
    parameter int SLOW_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              steady_i,
    output logic [FAST_W-1:0] cnt_o,
    output logic [FAST_W-1:0] cnt_next_o,
    output logic              period_end_o,
    output logic              slow_tick_o
);
    localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

    typedef struct packed {
        logic [FAST_W-1:0] cnt;
        logic [DIV_W-1:0]  div;
    } tb_regs_t;

    tb_regs_t cur_q, nxt_d;
    logic              pend;
    logic              tick;
    logic [DIV_W-1:0]  div_step;

    assign pend = &cur_q.cnt;

    generate
        if (SLOW_DIV == 1) begin : g_nodiv
            assign tick     = pend;
            assign div_step = '0;
        end else begin : g_div
            assign tick     = pend && (cur_q.div == DIV_LAST);
            assign div_step = (cur_q.div == DIV_LAST) ? '0 : cur_q.div + 1'b1;
        end
    endgenerate

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.cnt = cur_q.cnt + 1'b1;
        if (!steady_i) begin
            nxt_d.div = '0;
        end else if (pend) begin
            nxt_d.div = div_step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cnt_o        = cur_q.cnt;
    assign cnt_next_o   = rst ? '0 : nxt_d.cnt;
    assign period_end_o = pend;
    assign slow_tick_o  = tick;

endmodule

// File: rtl/sep_level.sv
module sep_level
    import sep_pkg::*;
#(
    parameter int FAST_W  = 8,
    parameter int RAMP_LG = 4
) (
    input  seq_state_e         state_i,
    input  logic [RAMP_LG:0]   ramp_i,
    input  logic [FAST_W-1:0]  cnt_i,
    output logic               level_o
);
    localparam int SH = FAST_W - RAMP_LG;

    logic [FAST_W:0] edge_pos;
    logic            before_edge;

    generate
        if (SH == 0) begin : g_noshift
            assign edge_pos = ramp_i;
        end else begin : g_shift
            assign edge_pos = {ramp_i, {SH{1'b0}}};
        end
    endgenerate

    assign before_edge = {1'b0, cnt_i} < edge_pos;

    always_comb begin
        unique case (state_i)
            ST_RISE:             level_o = before_edge;
            ST_FALL:             level_o = !before_edge;
            ST_RISE2ON, ST_ON:   level_o = 1'b1;
            default:             level_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sep_sequencer.sv
module sep_sequencer
    import sep_pkg::*;
#(
    parameter int DUTY_W  = 7,
    parameter int FAST_W  = 8,
    parameter int RAMP_LG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              hold_i,
    input  logic              period_end_i,
    input  logic              slow_tick_i,
    input  logic [FAST_W-1:0] cnt_next_i,
    output seq_state_e        state_o,
    output logic [RAMP_LG:0]  ramp_o,
    output logic [DUTY_W:0]   slow_o,
    output logic              steady_o,
    output logic              pwm_o
);
    localparam int PH_W = DUTY_W + 1;
    localparam logic [RAMP_LG:0] RAMP_N   = (RAMP_LG+1)'(2 ** RAMP_LG);
    localparam logic [RAMP_LG:0] RAMP_ONE = (RAMP_LG+1)'(1);
    localparam logic [PH_W-1:0]  FULL_MIN = PH_W'(2 ** PH_W - 3);

    typedef struct packed {
        seq_state_e       state;
        logic [RAMP_LG:0] ramp;
        logic [PH_W-1:0]  slow;
        logic [PH_W-1:0]  thr;
        logic             out;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;
    logic [PH_W-1:0] slow_inc;
    logic [PH_W-1:0] duty_x2;
    logic            lvl_d;

    assign slow_inc = cur_q.slow + 1'b1;
    assign duty_x2  = {duty_i, 1'b0};

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_OFF_START: begin
                if (slow_tick_i && !hold_i) begin
                    nxt_d.thr = duty_x2;
                    if (duty_x2 != '0) begin
                        nxt_d.state = ST_OFF;
                    end
                end
            end
            ST_OFF: begin
                if (slow_tick_i) begin
                    nxt_d.slow = slow_inc;
                    if (slow_inc <= cur_q.thr) begin
                        nxt_d.state = ST_OFF2RISE;
                    end
                end
            end
            ST_OFF2RISE: begin
                if (period_end_i) begin
                    nxt_d.state = ST_RISE;
                    nxt_d.ramp  = RAMP_ONE;
                end
            end
            ST_RISE: begin
                if (period_end_i) begin
                    if (cur_q.ramp == RAMP_N) begin
                        nxt_d.state = ST_RISE2ON;
                    end else begin
                        nxt_d.ramp = cur_q.ramp + 1'b1;
                    end
                end
            end
            ST_RISE2ON: begin
                if (period_end_i) begin
                    nxt_d.state = ST_ON;
                end
            end
            ST_ON: begin
                if (slow_tick_i && !hold_i) begin
                    nxt_d.slow = slow_inc;
                    if (!(slow_inc < cur_q.thr) && !(duty_x2 >= FULL_MIN)) begin
                        nxt_d.state = ST_FALL;
                        nxt_d.ramp  = RAMP_ONE;
                    end
                end
            end
            ST_FALL: begin
                if (period_end_i) begin
                    if (cur_q.ramp == RAMP_N) begin
                        nxt_d.state = ST_FALL2OFF;
                    end else begin
                        nxt_d.ramp = cur_q.ramp + 1'b1;
                    end
                end
            end
            ST_FALL2OFF: begin
                if (period_end_i) begin
                    nxt_d.state = ST_OFF_START;
                end
            end
            default: nxt_d.state = ST_OFF_START;
        endcase
        nxt_d.out = lvl_d;
    end

    sep_level #(
        .FAST_W  (FAST_W),
        .RAMP_LG (RAMP_LG)
    ) level_i (
        .state_i (nxt_d.state),
        .ramp_i  (nxt_d.ramp),
        .cnt_i   (cnt_next_i),
        .level_o (lvl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{state: ST_OFF_START, ramp: '0, slow: '0, thr: '0, out: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o  = cur_q.state;
    assign ramp_o   = cur_q.ramp;
    assign slow_o   = cur_q.slow;
    assign steady_o = is_steady(cur_q.state);
    assign pwm_o    = cur_q.out;

endmodule

// File: rtl/soft_edge_pwm.sv
module soft_edge_pwm
    import sep_pkg::*;
#(
    parameter int DUTY_W   = 7,
    parameter int FAST_W   = 8,
    parameter int SLOW_DIV = 8,
    parameter int RAMP_LG  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic              hold,
    output logic              pwm_out
);
    seq_state_e        seq_state;
    logic [RAMP_LG:0]  ramp_idx;
    logic [DUTY_W:0]   slow_cnt;
    logic [FAST_W-1:0] fast_cnt;
    logic [FAST_W-1:0] cnt_next;
    logic              period_end;
    logic              slow_tick;
    logic              steady;

    sep_timebase #(
        .FAST_W   (FAST_W),
        .SLOW_DIV (SLOW_DIV)
    ) timebase_i (
        .clk          (clk),
        .rst          (rst),
        .steady_i     (steady),
        .cnt_o        (fast_cnt),
        .cnt_next_o   (cnt_next),
        .period_end_o (period_end),
        .slow_tick_o  (slow_tick)
    );

    sep_sequencer #(
        .DUTY_W  (DUTY_W),
        .FAST_W  (FAST_W),
        .RAMP_LG (RAMP_LG)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .duty_i       (duty_cmd),
        .hold_i       (hold),
        .period_end_i (period_end),
        .slow_tick_i  (slow_tick),
        .cnt_next_i   (cnt_next),
        .state_o      (seq_state),
        .ramp_o       (ramp_idx),
        .slow_o       (slow_cnt),
        .steady_o     (steady),
        .pwm_o        (pwm_out)
    );

endmodule

// File: rtl/soft_edge_pwm_chk.sv
module soft_edge_pwm_chk
    import sep_pkg::*;
#(
    parameter int DUTY_W  = 7,
    parameter int FAST_W  = 8,
    parameter int RAMP_LG = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [DUTY_W-1:0] duty_cmd,
    input logic              hold,
    input logic              pwm_out,
    input seq_state_e        state,
    input logic [RAMP_LG:0]  ramp,
    input logic [DUTY_W:0]   slow,
    input logic [FAST_W-1:0] cnt
);
    localparam logic [FAST_W-1:0]  CNT_MAX = '1;
    localparam logic [RAMP_LG:0]   RAMP_N  = (RAMP_LG+1)'(2 ** RAMP_LG);
    localparam logic [DUTY_W-1:0]  DUTY_FULL = '1;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (state == ST_OFF_START && !pwm_out && slow == '0));

    p_zero_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF_START && duty_cmd == '0) |=> (state == ST_OFF_START && !pwm_out));

    p_mid_period_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt != CNT_MAX) |=> $stable(state));

    p_rise_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RISE && $past(state) != ST_RISE) |-> ($past(state) == ST_OFF2RISE && ramp == 1));

    p_rise_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RISE && cnt == CNT_MAX && ramp == RAMP_N) |=> (state == ST_RISE2ON && pwm_out));

    p_full_on_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && duty_cmd == DUTY_FULL) |=> (state == ST_ON));

    p_fall_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FALL && cnt == CNT_MAX && ramp == RAMP_N) |=> (state == ST_FALL2OFF && !pwm_out));

    p_fall_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FALL && $past(state) != ST_FALL) |-> ($past(state) == ST_ON));

    p_guard_high_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RISE2ON) |=> pwm_out);

    p_guard_low_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF2RISE && cnt != CNT_MAX) |=> !pwm_out);

    p_hold_on_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && hold) |=> (state == ST_ON && pwm_out && $stable(slow)));

    p_hold_start_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF_START && hold) |=> (state == ST_OFF_START && !pwm_out));

endmodule

bind soft_edge_pwm soft_edge_pwm_chk #(
    .DUTY_W  (DUTY_W),
    .FAST_W  (FAST_W),
    .RAMP_LG (RAMP_LG)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .duty_cmd (duty_cmd),
    .hold     (hold),
    .pwm_out  (pwm_out),
    .state    (seq_state),
    .ramp     (ramp_idx),
    .slow     (slow_cnt),
    .cnt      (fast_cnt)
);

// File: tb/soft_edge_pwm_tb_top.sv
`timescale 1ns/1ps
module soft_edge_pwm_tb_top;
    localparam int DUTY_W = 7;
    localparam int FAST_W = 5;
    localparam int SDIV   = 2;
    localparam int P      = 2 ** FAST_W;
    localparam int STEP   = P / 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DUTY_W-1:0] duty_cmd = '0;
    logic              hold = 1'b0;
    logic              pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int run_len [0:255];
    bit run_lvl [0:255];
    int run_n   = 0;
    bit cur_lvl = 0;
    int cur_len = 0;
    bit cap_en  = 0;

    always #4 clk = ~clk;

    soft_edge_pwm #(
        .DUTY_W   (DUTY_W),
        .FAST_W   (FAST_W),
        .SLOW_DIV (SDIV),
        .RAMP_LG  (4)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .duty_cmd (duty_cmd),
        .hold     (hold),
        .pwm_out  (pwm_out)
    );

    always @(negedge clk) begin
        if (cap_en) begin
            if (cur_len != 0 && pwm_out != cur_lvl) begin
                if (run_n < 256) begin
                    run_len[run_n] = cur_len;
                    run_lvl[run_n] = cur_lvl;
                end
                run_n++;
                cur_len = 1;
            end else begin
                cur_len++;
            end
            cur_lvl = pwm_out;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic start(input int d, input bit h);
        cap_en = 0;
        @(negedge clk);
        rst = 1'b1; duty_cmd = DUTY_W'(d); hold = h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_n = 0; cur_len = 0;
        cap_en = 1;
    endtask

    // R5: period k of the rise is high k*STEP, then low P-k*STEP
    task automatic chk_rise(input int base, input string what);
        int bad = -1;
        for (int k = 1; k <= 15; k++) begin
            if (!(run_lvl[base+2*k-2] == 1 && run_len[base+2*k-2] == k*STEP &&
                  run_lvl[base+2*k-1] == 0 && run_len[base+2*k-1] == P-k*STEP) && bad < 0)
                bad = k;
        end
        check(bad < 0, "R5", what, (bad < 0) ? 0 : run_len[base+2*bad-2],
              (bad < 0) ? 0 : bad*STEP);
    endtask

    // R7: period k of the fall is low k*STEP, then high P-k*STEP
    task automatic chk_fall(input int base, input string what);
        int bad = -1;
        for (int k = 1; k <= 15; k++) begin
            if (!(run_lvl[base+2*k-2] == 0 && run_len[base+2*k-2] == k*STEP &&
                  run_lvl[base+2*k-1] == 1 && run_len[base+2*k-1] == P-k*STEP) && bad < 0)
                bad = k;
        end
        check(bad < 0, "R7", what, (bad < 0) ? 0 : run_len[base+2*bad-2],
              (bad < 0) ? 0 : bad*STEP);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; duty_cmd = 7'd20; hold = 1'b0;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1", "output in reset", pwm_out, 0);
        rst = 1'b0;
        repeat (P - 2) @(negedge clk);
        check(pwm_out == 1'b0, "R1", "output after release", pwm_out, 0);
    endtask

    task automatic t_zero();
        start(0, 0);
        wait_clk(6000);
        check(run_n == 0 && cur_lvl == 0, "R2", "zero command idle runs", run_n, 0);
        @(negedge clk); duty_cmd = 7'd20;
        wait_clk(250);
        check(run_n >= 1, "R2", "resample after nonzero", run_n, 1);
    endtask

    task automatic t_cycle();
        int mn;
        start(20, 0);
        wait_clk(21500);
        check(run_n >= 94, "R3", "run count full cycle", run_n, 94);
        chk_rise(1, "first rise");
        check(run_lvl[31] == 1 && run_len[31] == (2 + 39*SDIV)*P, "R6",
              "first high stretch", run_len[31], (2 + 39*SDIV)*P);
        chk_fall(32, "first fall");
        check(run_lvl[62] == 0 && run_len[62] == (3 + (257-40)*SDIV)*P, "R4",
              "low stretch", run_len[62], (3 + (257-40)*SDIV)*P);
        chk_rise(63, "second rise");
        check(run_lvl[93] == 1 && run_len[93] == (2 + 40*SDIV)*P, "R3",
              "second high stretch", run_len[93], (2 + 40*SDIV)*P);
        mn = P * 1000;
        for (int i = 1; i < 94; i++) if (run_len[i] < mn) mn = run_len[i];
        check(mn >= STEP, "R8", "shortest pulse", mn, STEP);
    endtask

    task automatic t_duty1();
        start(1, 0);
        wait_clk(1000);
        chk_rise(1, "rise duty 1");
        check(run_lvl[31] == 1 && run_len[31] == (2 + SDIV)*P, "R6",
              "high stretch duty 1", run_len[31], (2 + SDIV)*P);
    endtask

    task automatic t_duty126();
        start(126, 0);
        wait_clk(17500);
        check(run_lvl[31] == 1 && run_len[31] == (2 + 251*SDIV)*P, "R6",
              "high stretch duty 126", run_len[31], (2 + 251*SDIV)*P);
    endtask

    task automatic t_duty127();
        start(127, 0);
        wait_clk(20000);
        check(run_n == 31 && cur_lvl == 1, "R6", "full-on runs", run_n, 31);
        check(cur_len > 19000, "R6", "full-on length", cur_len, 19000);
    endtask

    task automatic t_hold_on();
        int n0;
        start(20, 0);
        wait_clk(1500);
        check(cur_lvl == 1 && run_n == 31, "R9", "in steady on before hold", run_n, 31);
        @(negedge clk); hold = 1'b1;
        n0 = run_n;
        wait_clk(8000);
        check(run_n == n0 && cur_lvl == 1, "R9", "held high", run_n, n0);
        @(negedge clk); hold = 1'b0;
        wait_clk(3000);
        check(run_n > n0 && run_lvl[n0] == 1 && run_len[n0] > 8000, "R9",
              "resumes after hold", run_len[n0], 8000);
    endtask

    task automatic t_hold_start();
        start(20, 1);
        wait_clk(5000);
        check(run_n == 0 && cur_lvl == 0, "R9", "held in idle start", run_n, 0);
        @(negedge clk); hold = 1'b0;
        wait_clk(300);
        check(run_n >= 1, "R9", "leaves idle after release", run_n, 1);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_cycle();
        t_duty1();
        t_duty126();
        t_duty127();
        t_hold_on();
        t_hold_start();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule